// File: doc/BRIEF.md
# S/PDIF Control-Bit Word Collector

This block sits after a line decoder in a digital audio receiver. For each decoded subframe it takes the preamble class, the channel-status bit and the user bit. It packs them into 32-bit control words that software or a DMA engine can fetch. Each word holds sixteen user bits, one channel-status byte and a flag that marks the first word of a status block. A 192-frame block has 384 subframes, so it yields 24 words. Those words carry the 24 status bytes and the 48 user bytes of the block.

The subframe input is a valid/ready stream. The collector never applies back-pressure: `sf_ready` is always high, and a subframe is taken on every cycle in which `sf_valid` is high. The output is a holding register with a valid/ready pair. The word stays valid until it is read with `cw_ready`. When a new word completes while the held word is still unread, the new word replaces it and `cw_overrun` pulses for one cycle. A static select pin picks which channel supplies the status bits. User bits are taken from both channels.

Top module: `cs_user_collector`

## Requirements
- R1: After reset `cw_valid` and `cw_overrun` are low.
- R2: `sf_ready` is always high, and a subframe is accepted only in a cycle with `sf_valid` high. The preamble code `sf_pre` is decoded as follows: 2'b00 is channel A opening a block, 2'b01 is channel A, 2'b10 is channel B and 2'b11 is reserved. A subframe with the reserved code is ignored entirely.
- R3: Each sixteenth accepted subframe completes a word. `cw_valid` is high from the edge that accepts that subframe. User bits fill `cw_data[15:0]` in arrival order, the earliest in bit 0.
- R4: `cw_data[23:16]` holds the status bits of the selected channel, the earliest in bit 16. The channel is A when `sel_chan_b`=0 and B when it is 1. Bits 31:25 are zero.
- R5: `cw_data[24]` is 1 only on the first word completed after a subframe with code 2'b00.
- R6: A subframe with code 2'b00 discards any partial group and counts as the first subframe of a fresh group.
- R7: `cw_valid` stays high until a cycle with `cw_valid` and `cw_ready` both high, and then drops on the next edge unless a new word completes at that edge.
- R8: A word that completes while the held word is unread and not being read overwrites it, and `cw_overrun` is high for exactly the following cycle.
- R9: A full block of 384 subframes yields 24 words, of which exactly one carries the block-start flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_chan_b | input | 1 | Status channel select: 0 picks A, 1 picks B |
| sf_valid | input | 1 | Subframe fields are valid |
| sf_ready | output | 1 | Always high |
| sf_pre | input | 2 | Preamble class of the subframe |
| sf_cs | input | 1 | Channel-status bit of the subframe |
| sf_user | input | 1 | User bit of the subframe |
| cw_valid | output | 1 | Control word available |
| cw_ready | input | 1 | Read strobe; consumes the word when valid |
| cw_data | output | 32 | Control word |
| cw_overrun | output | 1 | One-cycle pulse when an unread word is overwritten |

## Verification
The bench uses the defaults: sixteen user bits, an eight-bit status byte and a 32-bit word. With these values a word completes after only sixteen subframes, so a whole 384-subframe block fits in a short run. That makes it possible to count the block-start flags across all 24 words. The small group size also lets the bench place a block start inside a partial group and trigger an overwrite within a few dozen cycles.

// File: rtl/cs_collect_pkg.sv
package cs_collect_pkg;

  typedef enum logic [1:0] {
    PRE_OPEN = 2'b00,
    PRE_CHA  = 2'b01,
    PRE_CHB  = 2'b10,
    PRE_RSVD = 2'b11
  } pre_e;

  typedef struct packed {
    logic take;
    logic open;
    logic pick;
    logic cs;
    logic user;
  } sf_event_t;

endpackage

// File: rtl/sf_classify.sv
module sf_classify
  import cs_collect_pkg::*;
(
  input  logic       sf_valid,
  input  logic [1:0] sf_pre,
  input  logic       sf_cs,
  input  logic       sf_user,
  input  logic       sel_chan_b,
  output sf_event_t  ev
);
  pre_e kind;
  logic is_b;

  always_comb begin
    kind    = pre_e'(sf_pre);
    is_b    = (kind == PRE_CHB);
    ev.take = sf_valid && (kind != PRE_RSVD);
    ev.open = sf_valid && (kind == PRE_OPEN);
    ev.pick = ev.take && (is_b == sel_chan_b);
    ev.cs   = sf_cs;
    ev.user = sf_user;
  end
endmodule

// File: rtl/bit_packer.sv
module bit_packer
  import cs_collect_pkg::*;
#(
  parameter int USER_W = 16,
  parameter int CS_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sf_event_t         ev,
  output logic              emit,
  output logic              emit_open,
  output logic [CS_W-1:0]   emit_cs,
  output logic [USER_W-1:0] emit_user
);
  localparam int CNT_W = (USER_W > 1) ? $clog2(USER_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(USER_W - 1);

  logic [USER_W-1:0] uacc, ubase, unext;
  logic [CS_W-1:0]   cacc, cbase, cnext;
  logic [CNT_W-1:0]  ucnt, cbasecnt;
  logic              open_pend, open_base;

  always_comb begin
    ubase     = ev.open ? '0 : uacc;
    cbase     = ev.open ? '0 : cacc;
    cbasecnt  = ev.open ? '0 : ucnt;
    open_base = ev.open | open_pend;
    if (USER_W > 1) unext = {ev.user, ubase[USER_W-1:1]};
    else            unext = ev.user;
    if (!ev.pick)    cnext = cbase;
    else if (CS_W > 1) cnext = {ev.cs, cbase[CS_W-1:1]};
    else             cnext = ev.cs;
    emit      = ev.take && (cbasecnt == LAST);
    emit_open = open_base;
    emit_cs   = cnext;
    emit_user = unext;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uacc      <= '0;
      cacc      <= '0;
      ucnt      <= '0;
      open_pend <= 1'b0;
    end else if (ev.take) begin
      if (emit) begin
        uacc      <= '0;
        cacc      <= '0;
        ucnt      <= '0;
        open_pend <= 1'b0;
      end else begin
        uacc      <= unext;
        cacc      <= cnext;
        ucnt      <= cbasecnt + 1'b1;
        open_pend <= open_base;
      end
    end
  end
endmodule

// File: rtl/word_holder.sv
module word_holder #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              rd_ready,
  output logic              held_valid,
  output logic [WORD_W-1:0] held_word,
  output logic              overrun
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_valid <= 1'b0;
      held_word  <= '0;
      overrun    <= 1'b0;
    end else begin
      overrun <= load && held_valid && !rd_ready;
      if (load) begin
        held_valid <= 1'b1;
        held_word  <= load_word;
      end else if (rd_ready) begin
        held_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cs_user_collector.sv
module cs_user_collector
  import cs_collect_pkg::*;
#(
  parameter int USER_W = 16,
  parameter int CS_W   = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_chan_b,
  input  logic              sf_valid,
  output logic              sf_ready,
  input  logic [1:0]        sf_pre,
  input  logic              sf_cs,
  input  logic              sf_user,
  output logic              cw_valid,
  input  logic              cw_ready,
  output logic [WORD_W-1:0] cw_data,
  output logic              cw_overrun
);
  localparam int USED_W = USER_W + CS_W + 1;
  localparam int PAD_W  = WORD_W - USED_W;

  sf_event_t         ev;
  logic              emit, emit_open;
  logic [CS_W-1:0]   emit_cs;
  logic [USER_W-1:0] emit_user;
  logic [WORD_W-1:0] word;

  assign sf_ready = 1'b1;

  sf_classify u_cls (
    .sf_valid  (sf_valid),
    .sf_pre    (sf_pre),
    .sf_cs     (sf_cs),
    .sf_user   (sf_user),
    .sel_chan_b(sel_chan_b),
    .ev        (ev)
  );

  bit_packer #(.USER_W(USER_W), .CS_W(CS_W)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev),
    .emit     (emit),
    .emit_open(emit_open),
    .emit_cs  (emit_cs),
    .emit_user(emit_user)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign word = {{PAD_W{1'b0}}, emit_open, emit_cs, emit_user};
    end else begin : g_nopad
      assign word = {emit_open, emit_cs, emit_user};
    end
  endgenerate

  word_holder #(.WORD_W(WORD_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (emit),
    .load_word (word),
    .rd_ready  (cw_ready),
    .held_valid(cw_valid),
    .held_word (cw_data),
    .overrun   (cw_overrun)
  );
endmodule

// File: rtl/cs_user_collector_chk.sv
module cs_user_collector_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sf_valid,
  input logic [1:0]  sf_pre,
  input logic        cw_valid,
  input logic        cw_ready,
  input logic [31:0] cw_data,
  input logic        cw_overrun
);
  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid && !cw_ready |=> cw_valid);

  // R4
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid |-> (cw_data[31:25] == 7'd0));

  // R8
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw_overrun |-> $past(cw_valid && !cw_ready));

  // R8
  overrun_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw_overrun |=> !cw_overrun);

  // R3
  word_from_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cw_valid) |-> $past(sf_valid && sf_pre != 2'b11));
endmodule

bind cs_user_collector cs_user_collector_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sf_valid  (sf_valid),
  .sf_pre    (sf_pre),
  .cw_valid  (cw_valid),
  .cw_ready  (cw_ready),
  .cw_data   (cw_data),
  .cw_overrun(cw_overrun)
);

// File: tb/cs_user_collector_test.sv
module cs_user_collector_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_chan_b = 1'b0;
  logic        sf_valid = 1'b0;
  logic        sf_ready;
  logic [1:0]  sf_pre = 2'b00;
  logic        sf_cs = 1'b0;
  logic        sf_user = 1'b0;
  logic        cw_valid;
  logic        cw_ready = 1'b0;
  logic [31:0] cw_data;
  logic        cw_overrun;

  int checks = 0;
  int fails  = 0;
  int ovr_seen = 0;
  int rdy_low = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cs_user_collector uut (
    .clk(clk), .rst_n(rst_n), .sel_chan_b(sel_chan_b),
    .sf_valid(sf_valid), .sf_ready(sf_ready), .sf_pre(sf_pre),
    .sf_cs(sf_cs), .sf_user(sf_user),
    .cw_valid(cw_valid), .cw_ready(cw_ready), .cw_data(cw_data),
    .cw_overrun(cw_overrun)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one accepted subframe, then an idle cycle with misleading fields (R2)
  task automatic send_sf(input logic [1:0] p, input logic c, input logic u);
    @(negedge clk);
    sf_valid = 1'b1; sf_pre = p; sf_cs = c; sf_user = u;
    @(negedge clk);
    if (cw_overrun) ovr_seen++;
    if (!sf_ready) rdy_low++;
    sf_valid = 1'b0; sf_pre = 2'b00; sf_cs = 1'b1; sf_user = 1'b1;
  endtask

  task automatic send_group(input bit open, input logic [7:0] a,
                            input logic [7:0] b, input logic [15:0] u,
                            input bit rsvd);
    for (int i = 0; i < 8; i++) begin
      send_sf((open && i == 0) ? 2'b00 : 2'b01, a[i], u[2*i]);
      if (rsvd) send_sf(2'b11, 1'b1, 1'b1);
      send_sf(2'b10, b[i], u[2*i+1]);
    end
  endtask

  task automatic read_word(input string req);
    @(negedge clk); cw_ready = 1'b1;
    @(negedge clk); cw_ready = 1'b0;
    chk(!cw_valid, req, {31'd0, cw_valid}, 32'd0);
  endtask

  task automatic t_reset;
    chk(!cw_valid, "R1 valid", {31'd0, cw_valid}, 32'd0);
    chk(!cw_overrun, "R1 overrun", {31'd0, cw_overrun}, 32'd0);
    chk(sf_ready, "R2 ready", {31'd0, sf_ready}, 32'd1);
  endtask

  task automatic t_chan_a;
    sel_chan_b = 1'b0; ovr_seen = 0; rdy_low = 0;
    send_group(1'b1, 8'hA5, 8'h3C, 16'h1234, 1'b0);
    chk(cw_valid, "R3 word ready", {31'd0, cw_valid}, 32'd1);
    chk(cw_data == 32'h01A51234, "R4 R5 chan A word", cw_data, 32'h01A51234);
    chk(ovr_seen == 0 && rdy_low == 0, "R2 R8 quiet", ovr_seen, 0);
    // held while not read
    repeat (3) @(negedge clk);
    chk(cw_valid && cw_data == 32'h01A51234, "R7 hold", cw_data, 32'h01A51234);
    read_word("R7 read clears");
  endtask

  task automatic t_no_open;
    send_group(1'b0, 8'h0F, 8'hF0, 16'hBEEF, 1'b0);
    chk(cw_data == 32'h000FBEEF, "R5 no flag", cw_data, 32'h000FBEEF);
    read_word("R7 read");
  endtask

  task automatic t_chan_b;
    sel_chan_b = 1'b1;
    send_group(1'b1, 8'h11, 8'hC3, 16'h5AA5, 1'b0);
    chk(cw_data == 32'h01C35AA5, "R4 chan B word", cw_data, 32'h01C35AA5);
    read_word("R7 read");
    sel_chan_b = 1'b0;
  endtask

  task automatic t_reserved;
    send_group(1'b0, 8'h81, 8'h7E, 16'h8001, 1'b1);
    chk(cw_data == 32'h00818001, "R2 reserved ignored", cw_data, 32'h00818001);
    read_word("R7 read");
  endtask

  task automatic t_restart;
    for (int i = 0; i < 5; i++) send_sf(i[0] ? 2'b10 : 2'b01, 1'b1, 1'b1);
    chk(!cw_valid, "R6 no early word", {31'd0, cw_valid}, 32'd0);
    send_group(1'b1, 8'h42, 8'h24, 16'h0F0F, 1'b0);
    chk(cw_data == 32'h01420F0F, "R6 restart", cw_data, 32'h01420F0F);
    read_word("R7 read");
  endtask

  task automatic t_overrun;
    ovr_seen = 0;
    send_group(1'b0, 8'h01, 8'h02, 16'h1111, 1'b0);
    chk(ovr_seen == 0, "R8 no overrun first", ovr_seen, 0);
    send_group(1'b0, 8'h77, 8'h02, 16'h2222, 1'b0);
    chk(ovr_seen == 1, "R8 overrun pulse", ovr_seen, 1);
    chk(cw_data == 32'h00772222, "R8 overwrite", cw_data, 32'h00772222);
    read_word("R7 read");
  endtask

  task automatic t_block;
    int words = 0;
    int flags = 0;
    for (int g = 0; g < 24; g++) begin
      logic [7:0] a = 8'(g * 9 + 3);
      send_group(g == 0, a, ~a, {a, ~a}, 1'b0);
      if (cw_valid) words++;
      if (cw_data[24]) flags++;
      if (g == 23)
        chk(cw_data == {8'h00, a, a, ~a}, "R9 last word", cw_data, {8'h00, a, a, ~a});
      read_word("R7 read");
    end
    chk(words == 24, "R9 words", words, 24);
    chk(flags == 1, "R9 flags", flags, 1);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_chan_a();
    t_no_open();
    t_chan_b();
    t_reserved();
    t_restart();
    t_overrun();
    t_block();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule